// File: doc/BRIEF.md
# Private Countdown Timer with Prescaler

This block is a per-processor countdown timer. Software reaches it through a small register window: a reload value, the live count, a control word and a one-bit event flag. When it is enabled, an 8-bit prescaler divides an incoming tick strobe by (prescaler + 1). Each prescaled step lowers the count by one. When the count runs out, the event flag is set and the timer either stops (one-shot) or reloads (periodic). An interrupt line reports the flag through a per-timer interrupt enable.

The value zero needs care. A reload or count of zero behaves differently depending on whether the prescaler is zero. With a zero prescaler, a zero value stops the timer or is replaced by the reload value, so it never raises a spurious event. With a nonzero prescaler, a zero value still takes one full prescaled period and then fires. Register writes take effect at the next clock edge. A tick that arrives in the same cycle as a register write is dropped.

Top module: `prv_countdown_timer`

## Requirements
- R1: After reset, the reload, count, control and status registers all read 0 and the interrupt output is low.
- R2: Offsets: 0x0 reload, 0x4 count, 0x8 control, 0xC status. Control fields: enable at bit 0, periodic at bit 1, interrupt enable at bit 2, prescaler at bits 15:8. All other control bits read 0. Status is bit 0. A write takes effect at the next edge, and a tick in a write cycle is discarded.
- R3: While the timer runs, the count falls by one every (prescaler + 1) accepted ticks.
- R4: A step taken at count 1 (or at count 0) sets status. A one-shot timer then holds 0 and stops.
- R5: A periodic timer reloads the count from the reload register at its event and keeps running.
- R6: The timer runs only when enable is set and either the prescaler or the count value is nonzero. With a nonzero prescaler, a zero count fires after one prescaled period.
- R7: A write of 0 to the reload register while enabled with prescaler 0 stops the timer with count 0 and no event.
- R8: A write of 0 to the count while enabled with prescaler 0 stops the timer without an event if it is one-shot or the reload is 0. If it is periodic with a nonzero reload, the count takes the reload value instead.
- R9: A periodic timer with reload 0 and prescaler 0 stops after its event. With a nonzero prescaler, it fires again every prescaled period.
- R10: Every control write restarts the prescaler phase and re-evaluates running from the new value. Clearing enable stops the countdown. Enabling a periodic timer with count 0 and prescaler 0 loads the count from the reload register.
- R11: Writing 1 to status bit 0 clears the flag. Writing 0 leaves it as it is.
- R12: The interrupt output is high exactly when status is set and the interrupt enable bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Input tick strobe, one cycle per tick |
| wr_en | input | 1 | Register write strobe |
| addr | input | 5 | Register byte offset in the 0x20 window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt: status AND interrupt enable |

## Verification
A wrong running flag or prescaler phase does not show at once. It appears as a count that moves on a tick where it should hold, or holds where it should move, within at most (prescaler + 1) ticks. A wrong zero-value decision shows at the next step as a status bit set with no expiry, or as an expiry that never comes. The bench therefore reads all four registers and the interrupt after every cycle and compares them with a requirement-level model. A divergence is reported in the cycle it first reaches a port.

// File: rtl/prv_timer_pkg.sv
// Package: shared offsets, control field layout and the control record type.
// Assumes a 32-bit register data path and a 0x20-byte window.
package prv_timer_pkg;
    localparam int WIN_ADDR_W = 5;
    localparam int PRESC_W    = 8;
    localparam int PRESC_LSB  = 8;
    localparam int BIT_EN     = 0;
    localparam int BIT_PER    = 1;
    localparam int BIT_IE     = 2;

    localparam logic [WIN_ADDR_W-1:0] OFF_LOAD  = 5'h00;
    localparam logic [WIN_ADDR_W-1:0] OFF_COUNT = 5'h04;
    localparam logic [WIN_ADDR_W-1:0] OFF_CTRL  = 5'h08;
    localparam logic [WIN_ADDR_W-1:0] OFF_STAT  = 5'h0C;

    typedef struct packed {
        logic [PRESC_W-1:0] presc;
        logic               irq_en;
        logic               periodic;
        logic               enable;
    } ctrl_t;
endpackage

// File: rtl/prv_timer_decode.sv
// Module: write decoder. Turns the write strobe and byte offset into one
// strobe per register. Assumes exact offsets; other offsets produce no strobe.
module prv_timer_decode
    import prv_timer_pkg::*;
(
    input  logic                  wr_en,
    input  logic [WIN_ADDR_W-1:0] addr,
    output logic                  we_load,
    output logic                  we_count,
    output logic                  we_ctrl,
    output logic                  we_stat
);
    // Match the offset against each register.
    always_comb begin
        we_load  = wr_en && (addr == OFF_LOAD);
        we_count = wr_en && (addr == OFF_COUNT);
        we_ctrl  = wr_en && (addr == OFF_CTRL);
        we_stat  = wr_en && (addr == OFF_STAT);
    end
endmodule

// File: rtl/prv_timer_presc.sv
// Module: prescaler phase counter. Emits one step for every (presc + 1)
// accepted ticks. Assumes the caller gates ticks with running and no-write.
module prv_timer_presc #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          tick_ok,
    input  logic [PW-1:0] presc,
    output logic          step
);
    logic [PW-1:0] phase_q;

    // A step is due when the phase has reached the prescaler value.
    always_comb step = tick_ok && (phase_q == presc);

    // Advance the phase on accepted ticks, wrap at the step, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            phase_q <= '0;
        else if (step)
            phase_q <= '0;
        else if (tick_ok)
            phase_q <= phase_q + 1'b1;
    end
endmodule

// File: rtl/prv_timer_ctrl_regs.sv
// Module: control word and status flag storage. Status is set by an event
// and cleared by writing one. Assumes the event and a write never coincide.
module prv_timer_ctrl_regs
    import prv_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  we_ctrl,
    input  logic  we_stat,
    input  ctrl_t ctrl_wr,
    input  logic  clr_bit,
    input  logic  evt,
    output ctrl_t ctrl_q,
    output logic  status_q
);
    // Capture the control word on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (we_ctrl)
            ctrl_q <= ctrl_wr;
    end

    // Set the flag on an event, clear it on a write of one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_q <= 1'b0;
        else if (evt)
            status_q <= 1'b1;
        else if (we_stat && clr_bit)
            status_q <= 1'b0;
    end
endmodule

// File: rtl/prv_timer_core.sv
// Module: countdown engine. Holds the reload value, the count and the running
// flag, and applies the zero-value rules on writes and steps. Assumes a step
// never arrives in a write cycle.
module prv_timer_core
    import prv_timer_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_load,
    input  logic          we_count,
    input  logic          we_ctrl,
    input  logic [CW-1:0] wdata,
    input  ctrl_t         ctrl_cur,
    input  ctrl_t         ctrl_wr,
    input  logic          step,
    output logic [CW-1:0] load_q,
    output logic [CW-1:0] count_q,
    output logic          run_q,
    output logic          evt
);
    logic [CW-1:0] load_d, count_d, val;
    logic          run_d, pz_cur, pz_new;

    // Work out next reload, count and running state from writes and steps.
    always_comb begin
        load_d  = load_q;
        count_d = count_q;
        run_d   = run_q;
        evt     = 1'b0;
        val     = '0;
        pz_cur  = (ctrl_cur.presc == '0);
        pz_new  = (ctrl_wr.presc == '0);
        if (we_load) begin
            load_d = wdata;
            if (ctrl_cur.enable && pz_cur && wdata == '0) begin
                count_d = '0;
                run_d   = 1'b0;
            end else begin
                count_d = wdata;
                if (ctrl_cur.enable && (!pz_cur || wdata != '0))
                    run_d = 1'b1;
            end
        end else if (we_count) begin
            if (ctrl_cur.enable && pz_cur && wdata == '0 &&
                (!ctrl_cur.periodic || load_q == '0)) begin
                count_d = '0;
                run_d   = 1'b0;
            end else begin
                val = (ctrl_cur.enable && ctrl_cur.periodic && pz_cur &&
                       wdata == '0) ? load_q : wdata;
                count_d = val;
                if (ctrl_cur.enable && (!pz_cur || val != '0))
                    run_d = 1'b1;
            end
        end else if (we_ctrl) begin
            if (ctrl_wr.enable) begin
                val = (ctrl_wr.periodic && pz_new && count_q == '0) ?
                      load_q : count_q;
                count_d = val;
                run_d   = !pz_new || (val != '0);
            end else begin
                run_d = 1'b0;
            end
        end else if (step) begin
            if (count_q <= CW'(1)) begin
                evt = 1'b1;
                if (ctrl_cur.periodic && !(pz_cur && load_q == '0)) begin
                    count_d = load_q;
                end else begin
                    count_d = '0;
                    run_d   = 1'b0;
                end
            end else begin
                count_d = count_q - 1'b1;
            end
        end
    end

    // Register the engine state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q  <= '0;
            count_q <= '0;
            run_q   <= 1'b0;
        end else begin
            load_q  <= load_d;
            count_q <= count_d;
            run_q   <= run_d;
        end
    end
endmodule

// File: rtl/prv_countdown_timer.sv
// Module: top of the private countdown timer. Wires decode, control storage,
// prescaler and countdown engine, and provides the read mux and interrupt.
// Assumes DATA_W covers the control field layout (at least 16 bits).
module prv_countdown_timer
    import prv_timer_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_in,
    input  logic                  wr_en,
    input  logic [WIN_ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0]     wdata,
    output logic [DATA_W-1:0]     rdata,
    output logic                  irq
);
    logic          we_load, we_count, we_ctrl, we_stat;
    logic          step, evt, run_q, status_q, tick_ok, phase_clr;
    logic [DATA_W-1:0] load_q, count_q;
    ctrl_t         ctrl_q, ctrl_wr;

    prv_timer_decode u_dec (
        .wr_en(wr_en), .addr(addr),
        .we_load(we_load), .we_count(we_count),
        .we_ctrl(we_ctrl), .we_stat(we_stat)
    );

    // Pick the control fields out of the write data.
    always_comb begin
        ctrl_wr.presc    = wdata[PRESC_LSB +: PRESC_W];
        ctrl_wr.irq_en   = wdata[BIT_IE];
        ctrl_wr.periodic = wdata[BIT_PER];
        ctrl_wr.enable   = wdata[BIT_EN];
    end

    prv_timer_ctrl_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we_ctrl(we_ctrl), .we_stat(we_stat),
        .ctrl_wr(ctrl_wr), .clr_bit(wdata[0]), .evt(evt),
        .ctrl_q(ctrl_q), .status_q(status_q)
    );

    // Accept a tick only while running and with no write in the cycle.
    always_comb begin
        tick_ok   = tick_in && run_q && !wr_en;
        phase_clr = we_load || we_count || we_ctrl;
    end

    prv_timer_presc #(.PW(PRESC_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr), .tick_ok(tick_ok),
        .presc(ctrl_q.presc), .step(step)
    );

    prv_timer_core #(.CW(DATA_W)) u_core (
        .clk(clk), .rst_n(rst_n), .we_load(we_load), .we_count(we_count),
        .we_ctrl(we_ctrl), .wdata(wdata), .ctrl_cur(ctrl_q), .ctrl_wr(ctrl_wr),
        .step(step), .load_q(load_q), .count_q(count_q), .run_q(run_q),
        .evt(evt)
    );

    // Read mux: registers by offset, zero elsewhere.
    always_comb begin
        rdata = '0;
        case (addr)
            OFF_LOAD:  rdata = load_q;
            OFF_COUNT: rdata = count_q;
            OFF_CTRL: begin
                rdata[PRESC_LSB +: PRESC_W] = ctrl_q.presc;
                rdata[BIT_IE]  = ctrl_q.irq_en;
                rdata[BIT_PER] = ctrl_q.periodic;
                rdata[BIT_EN]  = ctrl_q.enable;
            end
            OFF_STAT:  rdata[0] = status_q;
            default:   rdata = '0;
        endcase
    end

    // Interrupt output gated by the interrupt enable.
    always_comb irq = status_q && ctrl_q.irq_en;
endmodule

// File: rtl/prv_timer_checker.sv
// Module: property checker for the countdown timer, bound to the top.
// Assumes it sees the top's ports plus its running flag, count and status.
module prv_timer_checker
    import prv_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_in,
    input logic                  wr_en,
    input logic [WIN_ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]      wdata,
    input logic                  irq,
    input logic                  run,
    input logic [CNT_W-1:0]      count,
    input logic                  status,
    input logic                  ctrl_en,
    input logic [PRESC_W-1:0]    presc
);
    // R6: running requires the enable bit.
    p_run_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> ctrl_en);

    // R7: zero reload with prescaler 0 stops without an event.
    p_zero_load_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_LOAD && wdata == '0 && ctrl_en && presc == '0)
        |=> (!run && count == '0 && status == $past(status)));

    // R4: a stopped timer with no write holds its count.
    p_stopped_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !wr_en) |=> $stable(count));

    // R4: a step at count 1 with prescaler 0 sets status.
    p_expiry_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick_in && !wr_en && presc == '0 && count == CNT_W'(1))
        |=> status);

    // R11: writing one to status clears it and drops the interrupt.
    p_w1c_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_STAT && wdata[0]) |=> (!status && !irq));

    // R10: clearing enable stops the countdown.
    p_disable_stops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFF_CTRL && !wdata[0]) |=> !run);
endmodule

bind prv_countdown_timer prv_timer_checker #(.CNT_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .irq(irq), .run(run_q), .count(count_q),
    .status(status_q), .ctrl_en(ctrl_q.enable), .presc(ctrl_q.presc)
);

// File: tb/prv_countdown_timer_tb_top.sv
`timescale 1ns/1ps
module prv_countdown_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    // Requirement-level model state.
    logic [31:0] m_load = 0, m_cnt = 0;
    logic        m_en = 0, m_per = 0, m_ie = 0, m_st = 0, m_run = 0;
    logic [7:0]  m_pre = 0, m_pc = 0;

    always #4 clk = ~clk;

    prv_countdown_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        addr = a;
        #0.2;
        v = rdata;
    endtask

    function automatic logic [31:0] m_ctrl_word();
        return {16'h0, m_pre, 5'h0, m_ie, m_per, m_en};
    endfunction

    // Model: writes win over ticks; apply R3..R11 rules.
    task automatic m_update(input bit w, input logic [4:0] a,
                            input logic [31:0] d, input bit tk);
        logic [31:0] v;
        if (w) begin
            case (a)
                5'h00: begin
                    m_load = d;
                    if (m_en && m_pre == 0 && d == 0) begin m_cnt = 0; m_run = 0; end
                    else begin
                        m_cnt = d;
                        if (m_en && (m_pre != 0 || d != 0)) m_run = 1;
                    end
                    m_pc = 0;
                end
                5'h04: begin
                    if (m_en && m_pre == 0 && d == 0 && (!m_per || m_load == 0)) begin
                        m_cnt = 0; m_run = 0;
                    end else begin
                        v = (m_en && m_per && m_pre == 0 && d == 0) ? m_load : d;
                        m_cnt = v;
                        if (m_en && (m_pre != 0 || v != 0)) m_run = 1;
                    end
                    m_pc = 0;
                end
                5'h08: begin
                    m_en = d[0]; m_per = d[1]; m_ie = d[2]; m_pre = d[15:8];
                    if (m_en) begin
                        v = (m_per && m_pre == 0 && m_cnt == 0) ? m_load : m_cnt;
                        m_cnt = v;
                        m_run = (m_pre != 0 || v != 0);
                    end else m_run = 0;
                    m_pc = 0;
                end
                5'h0C: if (d[0]) m_st = 0;
                default: ;
            endcase
        end else if (tk && m_run) begin
            if (m_pc == m_pre) begin
                m_pc = 0;
                if (m_cnt <= 1) begin
                    m_st = 1;
                    if (m_per && !(m_pre == 0 && m_load == 0)) m_cnt = m_load;
                    else begin m_cnt = 0; m_run = 0; end
                end else m_cnt = m_cnt - 1;
            end else m_pc = m_pc + 1;
        end
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(5'h00, v); chk(tag, "reload", v, m_load);
        rd(5'h04, v); chk(tag, "count", v, m_cnt);
        rd(5'h08, v); chk(tag, "control", v, m_ctrl_word());
        rd(5'h0C, v); chk(tag, "status", v, {31'h0, m_st});
        chk(tag, "irq", {31'h0, irq}, {31'h0, m_st & m_ie});
    endtask

    task automatic cyc(input bit w, input logic [4:0] a, input logic [31:0] d,
                       input bit tk, input string tag);
        wr_en = w; addr = a; wdata = d; tick_in = tk;
        @(posedge clk);
        #1;
        wr_en = 0; tick_in = 0;
        m_update(w, a, d, tk);
        check_all(tag);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 5'h00, 0, 1, tag);
    endtask

    task automatic peek(input logic [4:0] a, input string tag, input string what,
                        input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, what, v, exp);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int r;
        void'($urandom(32'h5EED_2024));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1: reset state
        check_all("R1");
        chk("R1", "irq after reset", {31'h0, irq}, 32'h0);

        // R2: field layout and readback masking
        cyc(1, 5'h08, 32'hABCD_03FE, 0, "R2");
        peek(5'h08, "R2", "control readback", 32'h0000_0306);
        cyc(1, 5'h08, 32'h0, 0, "R2");

        // R3: prescaler 2 divides ticks by 3
        cyc(1, 5'h00, 32'd4, 0, "R3");
        cyc(1, 5'h08, 32'h0000_0201, 0, "R3");
        ticks(6, "R3");
        peek(5'h04, "R3", "count after 6 ticks", 32'd2);
        // R4: one-shot expiry, then hold at 0
        ticks(6, "R4");
        peek(5'h0C, "R4", "status at expiry", 32'd1);
        ticks(3, "R4");
        peek(5'h04, "R4", "count held", 32'd0);
        // R11: write one clears
        cyc(1, 5'h0C, 32'h0, 0, "R11");
        peek(5'h0C, "R11", "status after zero write", 32'd1);
        cyc(1, 5'h0C, 32'h1, 0, "R11");
        peek(5'h0C, "R11", "status after clear", 32'd0);

        // R5: periodic reload, R12 interrupt
        cyc(1, 5'h08, 32'h0, 0, "R5");
        cyc(1, 5'h00, 32'd2, 0, "R5");
        cyc(1, 5'h08, 32'h0000_0007, 0, "R5");
        ticks(2, "R5");
        peek(5'h04, "R5", "reloaded count", 32'd2);
        chk("R12", "irq with enable", {31'h0, irq}, 32'd1);
        cyc(1, 5'h08, 32'h0000_0003, 0, "R12");
        chk("R12", "irq masked", {31'h0, irq}, 32'd0);

        // R7: zero reload stops, no event
        cyc(1, 5'h0C, 32'h1, 0, "R7");
        cyc(1, 5'h00, 32'h0, 0, "R7");
        ticks(3, "R7");
        peek(5'h0C, "R7", "no event", 32'd0);
        peek(5'h04, "R7", "count zero", 32'd0);

        // R8: zero count write rules
        cyc(1, 5'h00, 32'd5, 0, "R8");
        cyc(1, 5'h04, 32'h0, 0, "R8");
        peek(5'h04, "R8", "periodic zero count takes reload", 32'd5);
        cyc(1, 5'h08, 32'h0000_0001, 0, "R8");
        cyc(1, 5'h04, 32'h0, 0, "R8");
        ticks(2, "R8");
        peek(5'h0C, "R8", "one-shot zero count no event", 32'd0);

        // R9: periodic reload 0
        cyc(1, 5'h08, 32'h0, 0, "R9");
        cyc(1, 5'h00, 32'h0, 0, "R9");
        cyc(1, 5'h08, 32'h0000_0003, 0, "R9");
        cyc(1, 5'h04, 32'd2, 0, "R9");
        ticks(4, "R9");
        peek(5'h0C, "R9", "event with prescaler 0", 32'd1);
        cyc(1, 5'h0C, 32'h1, 0, "R9");
        ticks(3, "R9");
        peek(5'h0C, "R9", "stopped after event", 32'd0);
        cyc(1, 5'h08, 32'h0000_0103, 0, "R9");
        ticks(2, "R9");
        peek(5'h0C, "R9", "retrigger first", 32'd1);
        cyc(1, 5'h0C, 32'h1, 0, "R9");
        ticks(2, "R9");
        peek(5'h0C, "R9", "retrigger second", 32'd1);

        // R6: run condition
        cyc(1, 5'h08, 32'h0, 0, "R6");
        cyc(1, 5'h0C, 32'h1, 0, "R6");
        cyc(1, 5'h08, 32'h0000_0001, 0, "R6");
        ticks(3, "R6");
        peek(5'h0C, "R6", "zero count prescaler 0 idle", 32'd0);
        cyc(1, 5'h08, 32'h0000_0101, 0, "R6");
        ticks(2, "R6");
        peek(5'h0C, "R6", "zero count prescaler 1 fires", 32'd1);

        // R10: disable stops; periodic enable reloads zero count
        cyc(1, 5'h00, 32'd3, 0, "R10");
        cyc(1, 5'h08, 32'h0000_0001, 0, "R10");
        ticks(1, "R10");
        cyc(1, 5'h08, 32'h0, 0, "R10");
        ticks(3, "R10");
        peek(5'h04, "R10", "count frozen", 32'd2);
        cyc(1, 5'h04, 32'h0, 0, "R10");
        cyc(1, 5'h08, 32'h0000_0003, 0, "R10");
        peek(5'h04, "R10", "enable loads reload", 32'd3);

        // Random mix checked against the model
        for (int i = 0; i < 3000; i++) begin
            r = $urandom % 12;
            d = ($urandom % 4 == 0) ? ($urandom % 16) : ($urandom % 4);
            case (r)
                0: cyc(1, 5'h00, d, 1, "R7");
                1: cyc(1, 5'h04, d, 1, "R8");
                2: cyc(1, 5'h08, {16'($urandom), 8'($urandom % 3),
                                  5'($urandom), 3'($urandom)}, 1, "R10");
                3: cyc(1, 5'h0C, $urandom, 0, "R11");
                4: cyc(1, 5'h10, $urandom, 1, "R2");
                5: cyc(0, 5'h00, 0, 0, "R3");
                default: cyc(0, 5'h00, 0, 1, "R3");
            endcase
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule